// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command-register controller of a byte-wide flash memory. It runs on a system clock. It samples the active-low chip-enable, output-enable and write-enable strobes together with an address and a data byte. A strobe that passes the write-inhibit rules and a minimum-width filter becomes a single write event. The controller then steps through the unlock-prefixed command sequences. When a sequence completes, it sends a one-cycle start pulse, with the target address and data byte, to a separate embedded-operation engine. That engine does the programming and erasing, owns their timing, and reports busy.

The block also drives the read-data mux. In normal mode the mux passes array data through. In identification mode it returns the maker code, the device code, or the boot-block lock status, depending on the read address. The boot-block lock can only be set and never cleared. Once it is set, program and block-erase requests aimed at the boot block are dropped. A chip erase still goes out, and the engine uses the lock output to skip the boot block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Every command begins with two writes: AAh to command address 555h, then 55h to 2AAh. Only address bits [10:0] are compared against command addresses, so the upper address bits are don't-care.
- R2: A third write of A0h to 555h arms programming. The next write, to any address, produces a one-cycle `prog_start` pulse with `op_addr`/`op_data` equal to that write's address and data.
- R3: Third-cycle 80h@555h, then AAh@555h, 55h@2AAh and 10h@555h, produces a one-cycle `chip_erase_start` pulse.
- R4: The same five-write erase prefix followed by 30h at any address produces a one-cycle `block_erase_start` pulse with `op_addr` equal to that address.
- R5: The erase prefix followed by 40h@555h sets `boot_locked` and enters identification mode. No command clears the lock; only reset does.
- R6: Outside identification mode a read returns `array_rdata`. Third-cycle 90h@555h enters identification mode. There, a read with address bits [7:0] = 00h returns 9Dh, and a read with bits [7:0] = 01h returns 1Eh when `TOP_BOOT`=1, or 2Eh otherwise.
- R7: In identification mode, a read inside the boot block with A1=1 and A0=0 returns the lock state on bit 0 and zero elsewhere. The boot block is the region whose address bits above `BOOT_AW` are all ones when `TOP_BOOT`=1, or all zeros otherwise.
- R8: Identification mode ends on a write of F0h to any address, or on AAh@555h, 55h@2AAh, F0h@555h. Any other write leaves the block in identification mode.
- R9: A strobe is inhibited, and produces no write, while `oe_n` is low or `ce_n` or `we_n` is high.
- R10: A write counts only after the strobe has been active for at least `FILTER_CYCLES` sampled clock edges. A shorter pulse has no effect. Address and data are taken from the strobe's last active cycle.
- R11: Outside identification mode, a write that does not match the expected address and data of the current step returns the block to the idle read state.
- R12: Writes that complete while `busy` is high are ignored.
- R13: While locked, program and block-erase requests aimed at the boot block produce no start pulse. Chip erase still starts.
- R14: `rdata` is zero unless both `ce_n` and `oe_n` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address for reads and writes |
| wdata | input | 8 | Write data byte |
| busy | input | 1 | Embedded-operation engine is working |
| array_rdata | input | 8 | Data read from the array |
| rdata | output | 8 | Read data returned to the bus |
| prog_start | output | 1 | One-cycle byte-program request |
| chip_erase_start | output | 1 | One-cycle chip-erase request |
| block_erase_start | output | 1 | One-cycle block-erase request |
| op_addr | output | AW | Target address of the request |
| op_data | output | 8 | Data byte of a program request |
| boot_locked | output | 1 | Boot-block lock state |

## Verification
Several properties are checked on every cycle by assertions:
- At most one start request is raised at a time.
- A program start only follows the armed program step.
- A write that completes during busy leaves the sequencer state and the lock unchanged.
- The lock never falls once set.
- A locked boot block never receives a block-erase request.
- Each filtered write is a single-cycle event taken from a strobe that had output-enable high.

The bench scenarios cover what needs whole sequences:
- the branching of the third and sixth command bytes;
- the return to idle after a wrong step;
- rejection of short pulses and inhibited strobes;
- the identification read codes and both exit paths;
- the dropping of boot-block requests after the lock is set.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ERA3,
    ST_ERA4,
    ST_ERA5,
    ST_IDM,
    ST_IDX1,
    ST_IDX2
  } seq_state_e;

  localparam int unsigned CMD_AW = 11;
  localparam logic [CMD_AW-1:0] CA_FIRST  = 11'h555;
  localparam logic [CMD_AW-1:0] CA_SECOND = 11'h2AA;

  localparam byte_t K_UNL_A  = 8'hAA;
  localparam byte_t K_UNL_B  = 8'h55;
  localparam byte_t K_PROG   = 8'hA0;
  localparam byte_t K_ERASE  = 8'h80;
  localparam byte_t K_CHIP   = 8'h10;
  localparam byte_t K_BLOCK  = 8'h30;
  localparam byte_t K_LOCK   = 8'h40;
  localparam byte_t K_IDENT  = 8'h90;
  localparam byte_t K_EXIT   = 8'hF0;
  localparam byte_t K_MAKER  = 8'h9D;
  localparam byte_t K_DEVTOP = 8'h1E;
  localparam byte_t K_DEVBOT = 8'h2E;

endpackage

// File: rtl/flash_wr_filter.sv
module flash_wr_filter
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW     = 19,
  parameter int unsigned FILTER = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  byte_t         wdata,
  output logic          wr_o,
  output logic [AW-1:0] wr_addr_o,
  output byte_t         wr_data_o
);

  localparam int unsigned CW = $clog2(FILTER + 1);
  localparam logic [CW-1:0] LIM = CW'(FILTER);

  logic          strobe;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  logic          cap_en;
  logic [AW-1:0] a_q;
  byte_t         d_q;

  assign strobe = !ce_n && !we_n;

  always_comb begin
    cnt_d  = cnt_q;
    wr_d   = 1'b0;
    cap_en = 1'b0;
    if (strobe && oe_n) begin
      cap_en = 1'b1;
      if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    end else if (strobe) begin
      cnt_d = '0;
    end else begin
      cnt_d = '0;
      wr_d  = (cnt_q == LIM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wr_q  <= 1'b0;
      a_q   <= '0;
      d_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
      if (cap_en) begin
        a_q <= addr;
        d_q <= wdata;
      end
    end
  end

  assign wr_o      = wr_q;
  assign wr_addr_o = a_q;
  assign wr_data_o = d_q;

  a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  a_r9_oe_high_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(oe_n, 2));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW       = 19,
  parameter int unsigned BOOT_AW  = 14,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  byte_t         wr_data_i,
  input  logic          busy_i,
  output logic          prog_start_o,
  output logic          chip_erase_start_o,
  output logic          block_erase_start_o,
  output logic [AW-1:0] op_addr_o,
  output byte_t         op_data_o,
  output logic          id_mode_o,
  output logic          boot_locked_o
);

  localparam int unsigned TW = AW - BOOT_AW;
  localparam logic [TW-1:0] BOOT_TAG = TOP_BOOT ? {TW{1'b1}} : {TW{1'b0}};

  seq_state_e state_q, state_d;
  logic lock_q, lock_d;
  logic ps_q, ps_d, ce_q, ce_d, be_q, be_d;
  logic op_en;
  logic [AW-1:0] opa_q;
  byte_t opd_q;
  logic acc, at1, at2, boot_w;
  byte_t d;

  assign acc    = wr_i && !busy_i;
  assign d      = wr_data_i;
  assign at1    = (wr_addr_i[CMD_AW-1:0] == CA_FIRST);
  assign at2    = (wr_addr_i[CMD_AW-1:0] == CA_SECOND);
  assign boot_w = (wr_addr_i[AW-1:BOOT_AW] == BOOT_TAG);

  always_comb begin
    state_d = state_q;
    lock_d  = lock_q;
    ps_d    = 1'b0;
    ce_d    = 1'b0;
    be_d    = 1'b0;
    op_en   = 1'b0;
    if (acc) begin
      case (state_q)
        ST_READ: state_d = (at1 && d == K_UNL_A) ? ST_UNL1 : ST_READ;
        ST_UNL1: state_d = (at2 && d == K_UNL_B) ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          if (at1 && d == K_PROG)       state_d = ST_PROG;
          else if (at1 && d == K_ERASE) state_d = ST_ERA3;
          else if (at1 && d == K_IDENT) state_d = ST_IDM;
          else                          state_d = ST_READ;
        end
        ST_PROG: begin
          state_d = ST_READ;
          if (!(lock_q && boot_w)) begin
            ps_d  = 1'b1;
            op_en = 1'b1;
          end
        end
        ST_ERA3: state_d = (at1 && d == K_UNL_A) ? ST_ERA4 : ST_READ;
        ST_ERA4: state_d = (at2 && d == K_UNL_B) ? ST_ERA5 : ST_READ;
        ST_ERA5: begin
          state_d = ST_READ;
          if (at1 && d == K_CHIP) begin
            ce_d  = 1'b1;
            op_en = 1'b1;
          end else if (d == K_BLOCK) begin
            if (!(lock_q && boot_w)) begin
              be_d  = 1'b1;
              op_en = 1'b1;
            end
          end else if (at1 && d == K_LOCK) begin
            lock_d  = 1'b1;
            state_d = ST_IDM;
          end
        end
        ST_IDM: begin
          if (d == K_EXIT)                 state_d = ST_READ;
          else if (at1 && d == K_UNL_A)    state_d = ST_IDX1;
        end
        ST_IDX1: begin
          if (d == K_EXIT)                 state_d = ST_READ;
          else if (at2 && d == K_UNL_B)    state_d = ST_IDX2;
          else                             state_d = ST_IDM;
        end
        ST_IDX2: state_d = (d == K_EXIT) ? ST_READ : ST_IDM;
        default: state_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ;
      lock_q  <= 1'b0;
      ps_q    <= 1'b0;
      ce_q    <= 1'b0;
      be_q    <= 1'b0;
      opa_q   <= '0;
      opd_q   <= '0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
      ps_q    <= ps_d;
      ce_q    <= ce_d;
      be_q    <= be_d;
      if (op_en) begin
        opa_q <= wr_addr_i;
        opd_q <= wr_data_i;
      end
    end
  end

  assign prog_start_o        = ps_q;
  assign chip_erase_start_o  = ce_q;
  assign block_erase_start_o = be_q;
  assign op_addr_o           = opa_q;
  assign op_data_o           = opd_q;
  assign boot_locked_o       = lock_q;
  assign id_mode_o = (state_q == ST_IDM) || (state_q == ST_IDX1) || (state_q == ST_IDX2);

  a_r2_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ps_q, ce_q, be_q}));

  a_r2_prog_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ps_q |-> $past(state_q) == ST_PROG);

  a_r12_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && busy_i) |=> ($stable(state_q) && $stable(lock_q)));

  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  a_r13_no_locked_block_erase: assert property (@(posedge clk) disable iff (!rst_n)
    be_q |-> !(lock_q && opa_q[AW-1:BOOT_AW] == BOOT_TAG));

endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW       = 19,
  parameter int unsigned BOOT_AW  = 14,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic          id_mode,
  input  logic          locked,
  input  byte_t         array_rdata,
  output byte_t         rdata
);

  localparam int unsigned TW = AW - BOOT_AW;
  localparam logic [TW-1:0] BOOT_TAG = TOP_BOOT ? {TW{1'b1}} : {TW{1'b0}};
  localparam byte_t DEV_CODE = TOP_BOOT ? K_DEVTOP : K_DEVBOT;

  logic boot_r;
  assign boot_r = (addr[AW-1:BOOT_AW] == BOOT_TAG);

  always_comb begin
    rdata = '0;
    if (!ce_n && !oe_n) begin
      if (!id_mode)                            rdata = array_rdata;
      else if (boot_r && addr[1:0] == 2'b10)   rdata = {7'b0, locked};
      else if (addr[7:0] == 8'h00)             rdata = K_MAKER;
      else if (addr[7:0] == 8'h01)             rdata = DEV_CODE;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW            = 19,
  parameter int unsigned FILTER_CYCLES = 2,
  parameter int unsigned BOOT_AW       = 14,
  parameter bit          TOP_BOOT      = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          busy,
  input  logic [7:0]    array_rdata,
  output logic [7:0]    rdata,
  output logic          prog_start,
  output logic          chip_erase_start,
  output logic          block_erase_start,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          boot_locked
);

  logic [1:0]    rs_q;
  logic          rst_i_n;
  logic          wr;
  logic [AW-1:0] wr_addr;
  byte_t         wr_data;
  logic          id_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  flash_wr_filter #(.AW(AW), .FILTER(FILTER_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_i_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata),
    .wr_o(wr), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  flash_cmd_fsm #(.AW(AW), .BOOT_AW(BOOT_AW), .TOP_BOOT(TOP_BOOT)) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .wr_i(wr), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy),
    .prog_start_o(prog_start), .chip_erase_start_o(chip_erase_start),
    .block_erase_start_o(block_erase_start), .op_addr_o(op_addr),
    .op_data_o(op_data), .id_mode_o(id_mode), .boot_locked_o(boot_locked)
  );

  flash_id_mux #(.AW(AW), .BOOT_AW(BOOT_AW), .TOP_BOOT(TOP_BOOT)) u_mux (
    .ce_n(ce_n), .oe_n(oe_n), .addr(addr), .id_mode(id_mode),
    .locked(boot_locked), .array_rdata(array_rdata), .rdata(rdata)
  );

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  localparam int AW   = 19;
  localparam int FILT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, oe_n, we_n, busy;
  logic [AW-1:0] addr;
  logic [7:0] wdata, array_rdata, rdata, op_data;
  logic prog_start, chip_erase_start, block_erase_start, boot_locked;
  logic [AW-1:0] op_addr;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;

  typedef struct {
    int            kind;
    logic [AW-1:0] a;
    logic [7:0]    d;
    string         tag;
  } ev_t;
  ev_t exp_q[$];

  always #10 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .busy(busy), .array_rdata(array_rdata),
    .rdata(rdata), .prog_start(prog_start), .chip_erase_start(chip_erase_start),
    .block_erase_start(block_erase_start), .op_addr(op_addr), .op_data(op_data),
    .boot_locked(boot_locked)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected request for every start pulse seen.
  always @(negedge clk) begin
    if (mon_on && (prog_start || chip_erase_start || block_erase_start)) begin
      int k;
      k = prog_start ? 1 : (chip_erase_start ? 2 : 3);
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected start request", k, 0);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        check(k == e.kind, e.tag, k, e.kind);
        if (e.kind != 2) check(op_addr == e.a, e.tag, op_addr, e.a);
        if (e.kind == 1) check(op_data == e.d, e.tag, op_data, e.d);
      end
    end
  end

  task automatic expect_ev(input int k, input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    ev_t e;
    e.kind = k; e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drained(input string tag);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic wr_raw(input logic [AW-1:0] a, input logic [7:0] d, input int cyc,
                        input logic oe, input logic ce);
    @(negedge clk);
    addr = a; wdata = d; oe_n = oe; ce_n = ce; we_n = 1'b0;
    repeat (cyc) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_raw(a, d, FILT, 1'b1, 1'b0);
  endtask

  task automatic unlock();
    wr(19'h00555, 8'hAA);
    wr(19'h002AA, 8'h55);
  endtask

  task automatic erase_prefix();
    unlock();
    wr(19'h00555, 8'h80);
    unlock();
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    check(rdata == exp, tag, rdata, exp);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; busy = 1'b0;
    addr = '0; wdata = '0; array_rdata = 8'h5A;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // Reset state
    check(boot_locked == 1'b0, "R5 lock clear after reset", boot_locked, 0);
    check(rdata == 8'h00, "R14 idle rdata zero", rdata, 0);
    @(negedge clk); ce_n = 1'b0; #1;
    check(rdata == 8'h00, "R14 rdata zero with oe_n high", rdata, 0);
    ce_n = 1'b1;
    rd(19'h00000, 8'h5A, "R6 normal array read");

    // R1 R2 program, upper address bits ignored on command cycles
    wr(19'h4D555, 8'hAA);
    wr(19'h7A2AA, 8'h55);
    wr(19'h10555, 8'hA0);
    expect_ev(1, 19'h12345, 8'h3C, "R2 program request");
    wr(19'h12345, 8'h3C);
    drained("R1 R2 program sequence");

    // R3 chip erase
    erase_prefix();
    expect_ev(2, '0, '0, "R3 chip erase request");
    wr(19'h00555, 8'h10);
    drained("R3 chip erase sequence");

    // R4 block erase
    erase_prefix();
    expect_ev(3, 19'h20010, '0, "R4 block erase request");
    wr(19'h20010, 8'h30);
    drained("R4 block erase sequence");

    // R6 R7 R8 identification mode, single-write exit
    unlock(); wr(19'h00555, 8'h90);
    rd(19'h00000, 8'h9D, "R6 maker code");
    rd(19'h00001, 8'h1E, "R6 device code");
    rd(19'h7C002, 8'h00, "R7 lock status unlocked");
    wr(19'h00333, 8'h12);
    rd(19'h00000, 8'h9D, "R8 stray write keeps id mode");
    wr(19'h00123, 8'hF0);
    rd(19'h00000, 8'h5A, "R8 single F0 exit");

    // R8 three-write exit
    unlock(); wr(19'h00555, 8'h90);
    unlock(); wr(19'h00555, 8'hF0);
    rd(19'h00001, 8'h5A, "R8 full exit sequence");

    // R11 mismatch returns to idle
    unlock(); wr(19'h00555, 8'h80);
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h12);
    wr(19'h20000, 8'h30);
    wr(19'h00555, 8'h90);
    rd(19'h00000, 8'h5A, "R11 mismatch drops to read");
    drained("R11 no request after mismatch");

    // R10 short pulse filtered
    wr_raw(19'h00555, 8'hAA, FILT - 1, 1'b1, 1'b0);
    wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
    rd(19'h00000, 8'h5A, "R10 short pulse ignored");

    // R9 inhibit with oe_n low, then with ce_n high
    wr_raw(19'h00555, 8'hAA, FILT + 1, 1'b0, 1'b0);
    wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
    rd(19'h00000, 8'h5A, "R9 oe_n low inhibits");
    wr_raw(19'h00555, 8'hAA, FILT + 1, 1'b1, 1'b1);
    wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
    rd(19'h00000, 8'h5A, "R9 ce_n high inhibits");

    // R12 busy ignores writes
    unlock(); wr(19'h00555, 8'h90);
    busy = 1'b1;
    wr(19'h00000, 8'hF0);
    rd(19'h00000, 8'h9D, "R12 exit ignored while busy");
    busy = 1'b0;
    wr(19'h00000, 8'hF0);
    busy = 1'b1;
    unlock(); wr(19'h00555, 8'hA0); wr(19'h01000, 8'h77);
    busy = 1'b0;
    drained("R12 program ignored while busy");

    // R5 R7 lock
    erase_prefix();
    wr(19'h00555, 8'h40);
    check(boot_locked == 1'b1, "R5 lock set", boot_locked, 1);
    rd(19'h7C002, 8'h01, "R7 lock status locked");
    rd(19'h00000, 8'h9D, "R5 lock enters id mode");
    wr(19'h00000, 8'hF0);

    // R13 boot requests dropped while locked
    unlock(); wr(19'h00555, 8'hA0); wr(19'h7C100, 8'h00);
    erase_prefix(); wr(19'h7E000, 8'h30);
    drained("R13 boot program and erase dropped");
    erase_prefix();
    expect_ev(3, 19'h00100, '0, "R13 non-boot block erase");
    wr(19'h00100, 8'h30);
    erase_prefix();
    expect_ev(2, '0, '0, "R13 chip erase when locked");
    wr(19'h00555, 8'h10);
    drained("R13 allowed requests while locked");
    check(boot_locked == 1'b1, "R5 lock persistent", boot_locked, 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "final queue empty", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule